// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the address for one port of a synchronous, banked memory. In every clock cycle it picks an internal address by one of four actions. It can take an address supplied from outside, step its own counter forward by one, keep the counter where it is, or return to the address it most recently took from outside. The counter spans the bank number and the in-bank offset as one value, so a burst runs across bank boundaries without a break. After the last location of the top bank it wraps back to the start of bank 0.

The selected address drives the memory access in the same cycle, including a step or a return. No cycle is lost when a burst restarts. A second output gives the same address one cycle later, for a pipelined read path that has one extra cycle of output latency.

Top module: `burst_addr_gen`

## Requirements
- R1: The internal address is BANK_W+OFF_W bits wide (18 by default). The bank number is the upper BANK_W bits and appears on `bank_sel`. The in-bank offset is the lower OFF_W bits and appears on `bank_off`.
- R2: When `load_n` is 0, `int_addr` equals `ext_addr` in that same cycle.
- R3: When `load_n` is 1, `repeat_n` is 1 and `count_n` is 0, `int_addr` is the previous cycle's `int_addr` plus one, in the current cycle.
- R4: When `load_n`, `repeat_n` and `count_n` are all 1, `int_addr` equals the previous cycle's `int_addr`.
- R5: A step from offset all-ones in bank k gives offset 0 in bank k+1.
- R6: A step from offset all-ones in the top bank gives offset 0 in bank 0.
- R7: When `repeat_n` is 0 and `load_n` is 1, `int_addr` in that cycle equals the `ext_addr` captured at the most recent cycle with `load_n` at 0. Steps and holds do not change that captured value.
- R8: The priority is load, then repeat, then step, then hold. A cycle with both `load_n` and `repeat_n` at 0 uses `ext_addr` and also replaces the captured repeat address.
- R9: A synchronous active-high `rst` clears the counter, the repeat address and `int_addr_q` to 0.
- R10: `int_addr_q` equals `int_addr` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 18 | Address supplied from outside |
| load_n | input | 1 | Load strobe, active low |
| count_n | input | 1 | Count enable, active low |
| repeat_n | input | 1 | Return to the last loaded address, active low |
| int_addr | output | 18 | Internal address used in this cycle |
| bank_sel | output | 6 | Bank field of `int_addr` |
| bank_off | output | 12 | Offset field of `int_addr` |
| int_addr_q | output | 18 | `int_addr` delayed by one cycle |

## Verification
The bench builds the block with its default widths: 6 bank bits and 12 offset bits. With these widths a directed load can place the counter one step before an offset carry, and one step before the wrap from bank 63 to bank 0. Random loads spread over the whole 18-bit space, with steps biased in, also reach mid-range carries. Load and repeat occur together often enough to exercise the priority rule and the rule that refreshes the repeat address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_RPT  = 2'd2,
    ACT_LOAD = 2'd3
  } act_e;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_addr_pkg::*;
(
  input  logic load_n,
  input  logic count_n,
  input  logic repeat_n,
  output act_e act
);
  always_comb begin
    if (!load_n)        act = ACT_LOAD;
    else if (!repeat_n) act = ACT_RPT;
    else if (!count_n)  act = ACT_STEP;
    else                act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_rpt_reg.sv
module burst_rpt_reg #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_addr_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int OFF_W  = 12,
  localparam int AW    = BANK_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  act_e          act,
  input  logic [AW-1:0] ext_addr,
  input  logic [AW-1:0] rpt_addr,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0]     cnt_q;
  logic [OFF_W-1:0]  off_inc;
  logic [BANK_W-1:0] bank_inc;
  logic              off_carry;

  // Offset and bank are incremented as separate fields, with the offset carry going into the bank.
  always_comb begin
    off_carry = &cnt_q[OFF_W-1:0];
    off_inc   = cnt_q[OFF_W-1:0] + OFF_W'(1);
    bank_inc  = cnt_q[AW-1:OFF_W] + BANK_W'(off_carry);
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: cur_addr = ext_addr;
      ACT_RPT:  cur_addr = rpt_addr;
      ACT_STEP: cur_addr = {bank_inc, off_inc};
      default:  cur_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cur_addr;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int OFF_W  = 12,
  localparam int AW    = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ext_addr,
  input  logic              load_n,
  input  logic              count_n,
  input  logic              repeat_n,
  output logic [AW-1:0]     int_addr,
  output logic [BANK_W-1:0] bank_sel,
  output logic [OFF_W-1:0]  bank_off,
  output logic [AW-1:0]     int_addr_q
);
  act_e          act;
  logic [AW-1:0] rpt_q;
  logic          primed;

  burst_ctl u_ctl (
    .load_n   (load_n),
    .count_n  (count_n),
    .repeat_n (repeat_n),
    .act      (act)
  );

  burst_rpt_reg #(.AW(AW)) u_rpt (
    .clk    (clk),
    .rst    (rst),
    .cap_en (!load_n),
    .d      (ext_addr),
    .q      (rpt_q)
  );

  burst_counter #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .ext_addr (ext_addr),
    .rpt_addr (rpt_q),
    .cur_addr (int_addr)
  );

  assign bank_sel = int_addr[AW-1:OFF_W];
  assign bank_off = int_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      int_addr_q <= '0;
      primed     <= 1'b0;
    end else begin
      int_addr_q <= int_addr;
      primed     <= 1'b1;
    end
  end

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    !load_n |-> int_addr == ext_addr); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (primed && load_n && repeat_n && !count_n) |-> int_addr == $past(int_addr) + AW'(1)); // R3
  AST_HOLD_SAME: assert property (@(posedge clk) disable iff (rst)
    (primed && load_n && repeat_n && count_n) |-> int_addr == $past(int_addr)); // R4
  AST_BANK_CARRY: assert property (@(posedge clk) disable iff (rst)
    (primed && load_n && repeat_n && !count_n && (&$past(bank_off)) && !(&$past(bank_sel)))
      |-> (bank_off == '0 && bank_sel == $past(bank_sel) + BANK_W'(1))); // R5
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (primed && load_n && repeat_n && !count_n && (&$past(int_addr))) |-> int_addr == '0); // R6
  AST_RPT_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (load_n && !repeat_n) |-> int_addr == rpt_q); // R7
  AST_RPT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(load_n)) |-> $stable(rpt_q)); // R7
  AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (rst)
    primed |-> int_addr_q == $past(int_addr)); // R10
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int BW = 6;
  localparam int OW = 12;
  localparam int AW = BW + OW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          load_n, count_n, repeat_n;
  logic [AW-1:0] int_addr, int_addr_q;
  logic [BW-1:0] bank_sel;
  logic [OW-1:0] bank_off;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [AW-1:0] m_cnt, m_rpt, m_prev;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.BANK_W(BW), .OFF_W(OW)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .load_n(load_n),
    .count_n(count_n), .repeat_n(repeat_n), .int_addr(int_addr),
    .bank_sel(bank_sel), .bank_off(bank_off), .int_addr_q(int_addr_q)
  );

  function automatic logic [AW-1:0] exp_addr(input logic ld, input logic cn, input logic rp,
                                             input logic [AW-1:0] ext,
                                             input logic [AW-1:0] cnt,
                                             input logic [AW-1:0] rpt);
    if (!ld)      return ext;
    else if (!rp) return rpt;
    else if (!cn) return cnt + AW'(1);
    else          return cnt;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, check after settling, then advance the model at the following posedge.
  task automatic step(input logic ld, input logic cn, input logic rp,
                      input logic [AW-1:0] ext, input string req);
    logic [AW-1:0] e;
    @(negedge clk);
    load_n = ld; count_n = cn; repeat_n = rp; ext_addr = ext;
    #1;
    e = exp_addr(ld, cn, rp, ext, m_cnt, m_rpt);
    check(req, int_addr, e);
    check("R1_bank", {26'd0, bank_sel}, {26'd0, e[AW-1:OW]});
    check("R1_off", {20'd0, bank_off}, {20'd0, e[OW-1:0]});
    check("R10", int_addr_q, m_prev);
    m_cnt  = e;
    m_prev = e;
    if (!ld) m_rpt = ext;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; load_n = 1'b0; count_n = 1'b0; repeat_n = 1'b0; ext_addr = 18'h2ABCD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; load_n = 1'b1; count_n = 1'b1; repeat_n = 1'b1;
    #1;
    // R9: counter and repeat register cleared, pipeline copy cleared.
    check("R9_cnt", int_addr, '0);
    check("R9_pipe", int_addr_q, '0);
    repeat_n = 1'b0;
    #1;
    check("R9_rpt", int_addr, '0);
    m_cnt = '0; m_rpt = '0; m_prev = '0;
    step(1, 1, 1, 18'h00000, "R4");
    // R5: offset carry into next bank
    step(0, 1, 1, 18'h00FFF, "R2");
    step(1, 0, 1, 18'h3FFFF, "R5");
    check("R5_fields", {12'd0, bank_sel}, 18'd1);
    step(1, 0, 1, 18'h00000, "R3");
    step(1, 1, 1, 18'h12345, "R4");
    // R7: repeat returns to 0x00FFF with no gap
    step(1, 0, 0, 18'h12345, "R7");
    // R6: top bank wrap
    step(0, 1, 1, 18'h3FFFF, "R2");
    step(1, 0, 1, 18'h00000, "R6");
    step(1, 0, 1, 18'h00000, "R3");
    step(1, 1, 0, 18'h00000, "R7");
    // R8: load and repeat together take the new address and refresh the repeat register
    step(0, 0, 0, 18'h15555, "R8");
    step(1, 0, 1, 18'h0, "R3");
    step(1, 0, 0, 18'h0, "R8");
    check("R8_rpt", int_addr, 18'h15555);
    for (int i = 0; i < 3000; i++) begin
      logic ld, cn, rp;
      ld = ($urandom % 6) != 0;
      rp = ($urandom % 5) != 0;
      cn = ($urandom % 3) == 0;
      step(ld, cn, rp, AW'($urandom), "R8_rand");
      if (($urandom % 400) == 0) begin
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; load_n = 1'b1; count_n = 1'b1; repeat_n = 1'b1;
        #1;
        check("R9", int_addr, '0);
        check("R9_pipe", int_addr_q, '0);
        m_cnt = '0; m_rpt = '0; m_prev = '0;
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule